// File: doc/BRIEF.md
# Escalating Watchdog Controller

This controller supervises software by watching one of several timer expiry inputs. Once started, every expiration of the selected timer moves it one stage further along a fixed escalation path. The first stages raise interrupts that software answers by petting the watchdog. Later stages request a debug reset and then a power-on reset. Each stage output can be turned on or off in the configuration register. A prescale field lets one expiration stand for several pulses of the selected timer.

Software writes three registers over a simple 32-bit write bus. The configuration register holds the stage enables, the prescale count and the source index. The command register starts or stops the counter. The unlock register guards the stop command, so stopping the counter takes a key write followed by the stop command. Petting is a stop followed by a start, and it returns the escalation to its first stage.

Top module: `wdog_escalate`

## Requirements
- R1: After block reset all five outputs are low, the counter is stopped and no unlock is armed.
- R2: Writing a command word with bit 0 set and bit 1 clear to offset 0x8 starts the counter. Expiry pulses that arrive while the counter is stopped are not counted.
- R3: Configuration bits 3:0 (offset 0x0) pick the timer expiry input. Pulses on any other input are not counted.
- R4: Configuration bits 11:4 hold a prescale count N. An expiration occurs on every N-th counted pulse, and N = 0 behaves as N = 1.
- R5: The first expiration raises the local interrupt if configuration bit 12 is set, and the local fast interrupt if bit 13 is set.
- R6: The second expiration raises the remote interrupt if configuration bit 14 is set. The third expiration raises no output.
- R7: The fourth expiration raises the debug reset request if bit 15 is set. The fifth raises the power-on reset request if bit 16 is set. A disabled stage stays low.
- R8: A command word with bit 1 set stops the counter only if the write just before it to offset 0xC carried 0x0000C45A. Without that key write the stop is ignored.
- R9: Any command register write consumes an armed unlock. A write of any other value to offset 0xC disarms it.
- R10: An accepted stop returns the expiration count and the prescaler to zero and drops the three interrupt outputs. A later start counts again from the first stage.
- R11: The debug and power-on reset requests stay high until block reset, even after a stop.
- R12: When an accepted stop and a selected expiry pulse arrive in the same cycle, the stop wins and the pulse is not counted.
- R13: A start while the counter is running leaves the count unchanged. A command word with both bits set acts as a stop only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous block reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 4 | Byte offset of the register written |
| busWrData | input | 32 | Write data |
| timerExpiry | input | 16 | One-cycle expiry pulses, one per timer |
| intLocal | output | 1 | Local interrupt (stage 1) |
| fiqLocal | output | 1 | Local fast interrupt (stage 1) |
| intRemote | output | 1 | Remote interrupt (stage 2) |
| debugRstReq | output | 1 | Debug reset request (stage 4), sticky |
| porRstReq | output | 1 | Power-on reset request (stage 5), sticky |

## Verification
An accepted stop command can arrive in the same cycle as an expiry pulse on the selected timer. The two fight over the expiration count. The bench raises a stage-1 interrupt, arms the unlock, and then drives the stop write and the pulse on the same clock edge. It expects every interrupt to be low afterwards. After a restart, a single pulse must raise only the local interrupt and not the remote one, which shows that the colliding pulse was dropped and not counted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;
  localparam logic [3:0]  OFS_CFG    = 4'h0;
  localparam logic [3:0]  OFS_CMD    = 4'h8;
  localparam logic [3:0]  OFS_UNLOCK = 4'hC;
  localparam int          LAST_STAGE = 5;
  localparam int          CNT_W      = $clog2(LAST_STAGE + 1);

  // control-to-datapath strobes
  typedef struct packed {
    logic clear;
    logic tick;
  } wdgStrobe_t;

  typedef struct packed {
    logic porEn;
    logic dbgEn;
    logic remoteEn;
    logic fiqEn;
    logic localEn;
  } wdgEnables_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 4,
  parameter int PSC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  input  logic [NUM_SRC-1:0] timerExpiry,
  output wdgStrobe_t         strobe,
  output wdgEnables_t        enables
);
  localparam int SEL_W = 4;
  localparam int PAD_N = 1 << SEL_W;

  logic [PSC_W-1:0] period, pscCnt, periodEff;
  logic [SEL_W-1:0] srcSel;
  logic [PAD_N-1:0] expiryPad;
  logic running, unlockArmed;
  logic cfgWr, cmdWr, unlockWr, stopReq, startReq, pulseSeen, tick;

  assign cfgWr    = busWrEn && (busAddr == ADDR_W'(OFS_CFG));
  assign cmdWr    = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign unlockWr = busWrEn && (busAddr == ADDR_W'(OFS_UNLOCK));
  assign stopReq  = cmdWr && busWrData[1] && unlockArmed;
  assign startReq = cmdWr && busWrData[0] && !busWrData[1] && !running;

  always_comb begin
    expiryPad = '0;
    expiryPad[NUM_SRC-1:0] = timerExpiry;
  end

  assign periodEff = (period == '0) ? PSC_W'(1) : period;
  assign pulseSeen = running && expiryPad[srcSel] && !stopReq;
  assign tick      = pulseSeen && (pscCnt == periodEff - PSC_W'(1));
  assign strobe    = '{clear: stopReq, tick: tick};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables     <= '0;
      period      <= '0;
      srcSel      <= '0;
      unlockArmed <= 1'b0;
      running     <= 1'b0;
      pscCnt      <= '0;
    end else begin
      if (cfgWr) begin
        enables <= wdgEnables_t'(busWrData[16:12]);
        period  <= busWrData[4 +: PSC_W];
        srcSel  <= busWrData[SEL_W-1:0];
      end
      if (cmdWr)         unlockArmed <= 1'b0;
      else if (unlockWr) unlockArmed <= (busWrData == UNLOCK_KEY);
      if (stopReq)       running <= 1'b0;
      else if (startReq) running <= 1'b1;
      if (stopReq || startReq) pscCnt <= '0;
      else if (pulseSeen)      pscCnt <= tick ? '0 : pscCnt + PSC_W'(1);
    end
  end

  // R8: a stop without the key leaves the counter running
  a_r8_locked_stop: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWrData[1] && !unlockArmed && running) |=> running);
  // R9: any command write leaves the unlock disarmed
  a_r9_unlock_consumed: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !unlockArmed);
  // R2: nothing advances while stopped
  a_r2_idle_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    $past(!running && !startReq) |-> !strobe.tick || running);
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  wdgStrobe_t  strobe,
  input  wdgEnables_t enables,
  output logic        intLocal,
  output logic        fiqLocal,
  output logic        intRemote,
  output logic        debugRstReq,
  output logic        porRstReq
);
  logic [CNT_W-1:0] expCount, nextCount;

  assign nextCount = expCount + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expCount    <= '0;
      intLocal    <= 1'b0;
      fiqLocal    <= 1'b0;
      intRemote   <= 1'b0;
      debugRstReq <= 1'b0;
      porRstReq   <= 1'b0;
    end else if (strobe.clear) begin
      expCount  <= '0;
      intLocal  <= 1'b0;
      fiqLocal  <= 1'b0;
      intRemote <= 1'b0;
    end else if (strobe.tick && expCount != CNT_W'(LAST_STAGE)) begin
      expCount <= nextCount;
      case (nextCount)
        CNT_W'(1): begin
          intLocal <= enables.localEn;
          fiqLocal <= enables.fiqEn;
        end
        CNT_W'(2): intRemote <= enables.remoteEn;
        CNT_W'(4): debugRstReq <= debugRstReq | enables.dbgEn;
        CNT_W'(5): porRstReq   <= porRstReq | enables.porEn;
        default: ;
      endcase
    end
  end

  // R11: reset requests are sticky
  a_r11_por_sticky: assert property (@(posedge clk) disable iff (!rstN)
    porRstReq |=> porRstReq);
  a_r11_dbg_sticky: assert property (@(posedge clk) disable iff (!rstN)
    debugRstReq |=> debugRstReq);
  // R10: interrupts fall only on an accepted stop
  a_r10_int_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intLocal) |-> $past(strobe.clear));
  // R7: power-on reset only at the last stage
  a_r7_por_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(porRstReq) |-> expCount == CNT_W'(LAST_STAGE));
  // R7: the count saturates at the last stage
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rstN)
    expCount <= CNT_W'(LAST_STAGE));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  input  logic [NUM_SRC-1:0] timerExpiry,
  output logic               intLocal,
  output logic               fiqLocal,
  output logic               intRemote,
  output logic               debugRstReq,
  output logic               porRstReq
);
  wdgStrobe_t  strobe;
  wdgEnables_t enables;

  wdog_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .timerExpiry(timerExpiry),
    .strobe(strobe), .enables(enables)
  );

  wdog_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enables(enables),
    .intLocal(intLocal), .fiqLocal(fiqLocal), .intRemote(intRemote),
    .debugRstReq(debugRstReq), .porRstReq(porRstReq)
  );
endmodule

// File: tb/wdog_escalate_bench.sv
module wdog_escalate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 26;
  localparam logic [1:0] OP_WR = 2'd1, OP_PULSE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [15:0] pulse;
    logic [4:0]  expOut;  // {por, dbg, remote, fiq, local}
    logic [7:0]  req;
  } vec_t;

  // all stages enabled, prescale 1, source 2
  localparam vec_t VECS [N_VEC] = '{
    '{OP_WR,    4'h0, 32'h0001_F012, 16'h0,    5'b00000, 8'd3},  // R3 config
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00000, 8'd2},  // R2 stopped
    '{OP_WR,    4'h8, 32'h1,         16'h0,    5'b00000, 8'd2},  // R2 start
    '{OP_PULSE, 4'h0, 32'h0,         16'h0020, 5'b00000, 8'd3},  // R3 other source
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00011, 8'd5},  // R5
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00111, 8'd6},  // R6
    '{OP_WR,    4'h8, 32'h2,         16'h0,    5'b00111, 8'd8},  // R8 no key
    '{OP_WR,    4'hC, 32'h0000_C45A, 16'h0,    5'b00111, 8'd9},  // R9
    '{OP_WR,    4'h8, 32'h0,         16'h0,    5'b00111, 8'd9},  // R9 consume
    '{OP_WR,    4'h8, 32'h2,         16'h0,    5'b00111, 8'd9},  // R9
    '{OP_WR,    4'hC, 32'h0000_C45A, 16'h0,    5'b00111, 8'd9},  // R9
    '{OP_WR,    4'hC, 32'h0000_1234, 16'h0,    5'b00111, 8'd9},  // R9 disarm
    '{OP_WR,    4'h8, 32'h2,         16'h0,    5'b00111, 8'd9},  // R9
    '{OP_WR,    4'hC, 32'h0000_C45A, 16'h0,    5'b00111, 8'd10}, // R10
    '{OP_WR,    4'h8, 32'h2,         16'h0,    5'b00000, 8'd10}, // R10 stop
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00000, 8'd10}, // R10
    '{OP_WR,    4'h8, 32'h1,         16'h0,    5'b00000, 8'd10}, // R10 restart
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00011, 8'd10}, // R10 stage 1
    '{OP_WR,    4'h8, 32'h1,         16'h0,    5'b00011, 8'd13}, // R13
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00111, 8'd13}, // R13 stage 2
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b00111, 8'd6},  // R6 stage 3
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b01111, 8'd7},  // R7 stage 4
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b11111, 8'd7},  // R7 stage 5
    '{OP_WR,    4'hC, 32'h0000_C45A, 16'h0,    5'b11111, 8'd11}, // R11
    '{OP_WR,    4'h8, 32'h2,         16'h0,    5'b11000, 8'd11}, // R11 sticky
    '{OP_PULSE, 4'h0, 32'h0,         16'h0004, 5'b11000, 8'd11}  // R11
  };

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [15:0] timerExpiry = '0;
  logic intLocal, fiqLocal, intRemote, debugRstReq, porRstReq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_escalate u_wdog_escalate (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .timerExpiry(timerExpiry),
    .intLocal(intLocal), .fiqLocal(fiqLocal), .intRemote(intRemote),
    .debugRstReq(debugRstReq), .porRstReq(porRstReq)
  );

  function automatic logic [4:0] outs();
    return {porRstReq, debugRstReq, intRemote, fiqLocal, intLocal};
  endfunction

  task automatic check(input logic [4:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  // one cycle of bus write and/or expiry pulses, checked after the edge
  task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [15:0] p);
    @(negedge clk);
    busWrEn = wr; busAddr = a; busWrData = d; timerExpiry = p;
    @(negedge clk);
    busWrEn = 1'b0; timerExpiry = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    doReset();
    check(5'b00000, "R1 reset state");
    foreach (VECS[i]) begin
      step(VECS[i].op == OP_WR, VECS[i].addr, VECS[i].data,
           (VECS[i].op == OP_PULSE) ? VECS[i].pulse : 16'h0);
      check(VECS[i].expOut, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    doReset();
    check(5'b00000, "R1 R11 reset clears requests");

    // R4: prescale 3, local only, source 0
    step(1'b1, 4'h0, 32'h0000_1030, 16'h0);
    step(1'b1, 4'h8, 32'h1, 16'h0);
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00000, "R4 prescale two pulses");
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00001, "R4 prescale third pulse");

    // R4: prescale 0 acts as 1
    doReset();
    step(1'b1, 4'h0, 32'h0000_1000, 16'h0);
    step(1'b1, 4'h8, 32'h1, 16'h0);
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00001, "R4 prescale zero");

    // R7: no enables, five expirations raise nothing
    doReset();
    step(1'b1, 4'h0, 32'h0000_0013, 16'h0);
    step(1'b1, 4'h8, 32'h1, 16'h0);
    for (int k = 0; k < 6; k++) step(1'b0, 4'h0, 32'h0, 16'h0008);
    check(5'b00000, "R7 all stages disabled");

    // R12: stop and selected pulse in the same cycle
    doReset();
    step(1'b1, 4'h0, 32'h0000_5010, 16'h0);
    step(1'b1, 4'h8, 32'h1, 16'h0);
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00001, "R12 setup stage 1");
    step(1'b1, 4'hC, 32'h0000_C45A, 16'h0);
    step(1'b1, 4'h8, 32'h2, 16'h0001);
    check(5'b00000, "R12 stop wins");
    step(1'b1, 4'h8, 32'h1, 16'h0);
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00001, "R12 colliding pulse not counted");

    // R13: both command bits set acts as stop only
    step(1'b1, 4'hC, 32'h0000_C45A, 16'h0);
    step(1'b1, 4'h8, 32'h3, 16'h0);
    check(5'b00000, "R13 both bits stop");
    step(1'b0, 4'h0, 32'h0, 16'h0001);
    check(5'b00000, "R13 both bits do not start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule